// File: doc/BRIEF.md
# Opcode Addressing-Mode and Cycle Decoder

This block sits at the front of an 8-bit processor's sequencer. It takes one opcode byte and returns the addressing mode, a flag that says whether the byte is a defined instruction, and the number of clock cycles the instruction occupies. The cycle count comes in two forms. The base count is fixed once the opcode is known. The final count adds the conditional cycles: an indexed read whose address crosses a 256-byte page, and a relative branch that is taken, with one more cycle if the taken branch lands in another page.

Each defined opcode is placed by a fixed offset from the absolute-mode encoding of its family, and each mode moves the base count away from that family's absolute reference count. The block also forms the relative branch destination: the address after the offset byte plus the sign-extended 8-bit offset. It compares pages itself to find the far-branch cycle. Every output is registered, so results appear one clock after the inputs are presented. Fetching operands and executing the instruction happen elsewhere.

Top module: `opcode_cycle_decoder`

## Requirements
- R1: With `rst` high at a rising edge, the next outputs are `valid_o`=0, `mode_o`=0, `base_cyc_o`=0, `final_cyc_o`=0 and `target_o`=0. Otherwise every output reflects the inputs sampled at the preceding rising edge.
- R2: `mode_o` codes are 0 implied, 1 accumulator, 2 immediate, 3 zero page, 4 zero page+X, 5 zero page+Y, 6 absolute, 7 absolute+X, 8 absolute+Y, 9 indexed-indirect X, 10 indirect-indexed Y, 11 absolute indirect and 12 relative. The offsets from the absolute opcode are: zero page −0x08; zero page indexed +0x08; absolute+X +0x10; absolute+Y +0x0C (but +0x10 for the family at 0xAE); indexed-indirect −0x0C; indirect-indexed +0x04; absolute indirect +0x20; accumulator −0x04; immediate −0x04 for families whose absolute opcode has low bits 01 and −0x0C otherwise.
- R3: The operand families are listed by absolute opcode. Reads with immediate, zero page, zero page+X, absolute, absolute+X, absolute+Y, indexed-indirect and indirect-indexed: 0x0D, 0x2D, 0x4D, 0x6D, 0xAD, 0xCD, 0xED. Store with the same set minus immediate: 0x8D. Read-modify-write with accumulator, zero page, zero page+X, absolute and absolute+X: 0x0E, 0x2E, 0x4E, 0x6E. Read-modify-write without accumulator: 0xCE, 0xEE. Read with immediate, zero page, zero page+Y, absolute and absolute+Y: 0xAE. Store with zero page, zero page+Y and absolute: 0x8E. Read with immediate, zero page, zero page+X, absolute and absolute+X: 0xAC. Store with zero page, zero page+X and absolute: 0x8C. Reads with immediate, zero page and absolute: 0xCC, 0xEC. Read with zero page and absolute: 0x2C. Jump with absolute and absolute indirect: 0x4C. Call with absolute only: 0x20.
- R4: Base count = family reference + mode adjustment. The reference is 4 for all families except read-modify-write (6), jump (3) and call (6). The adjustment is −2 for immediate, −1 for zero page, +2 for indexed-indirect, +1 for indirect-indexed, +2 for absolute indirect and 0 for the other modes. Accumulator forms always take 2.
- R5: For stores and read-modify-write families, the absolute+X, absolute+Y and indirect-indexed forms carry one fixed extra cycle inside the base count, and `page_x` has no effect on them.
- R6: For read families in absolute+X, absolute+Y or indirect-indexed mode, `final_cyc_o` = base + `page_x`.
- R7: Implied single-byte opcodes: 0x18, 0x38, 0x58, 0x78, 0x98, 0xB8, 0xD8, 0xF8, 0x88, 0xA8, 0xC8, 0xE8, 0x8A, 0x9A, 0xAA, 0xBA, 0xCA and 0xEA take 2 cycles. 0x08 and 0x48 take 3, 0x28 and 0x68 take 4, 0x40 and 0x60 take 6, and 0x00 takes 7.
- R8: Opcodes whose low five bits are 0x10 are relative branches with base 2. The final count is 2 if `br_taken` is 0, 3 if taken within the same page, and 4 if taken to another page. `page_x` does not affect them.
- R9: `target_o` = `pc` + 1 + sign-extended `rel_off`, modulo 2^16. A branch is far when the upper byte of `target_o` differs from that of `pc`+1.
- R10: Every opcode not placed by R3, R7 or R8 gives `valid_o`=0 with mode, base and final all 0. For defined non-branch opcodes outside R6, `final_cyc_o` equals `base_cyc_o` whatever `page_x` and `br_taken` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 8 | Opcode byte to decode |
| page_x | input | 1 | Indexed address crossed a page |
| br_taken | input | 1 | Branch condition holds |
| pc | input | ADDR_W (16) | Address of the branch offset byte |
| rel_off | input | OFF_W (8) | Signed branch offset |
| valid_o | output | 1 | Opcode is defined |
| mode_o | output | 4 | Addressing mode code (R2) |
| base_cyc_o | output | CYC_W (4) | Cycles without conditional extras |
| final_cyc_o | output | CYC_W (4) | Cycles including conditional extras |
| target_o | output | ADDR_W (16) | Relative branch destination |

## Verification
The hardest case to reach is a taken branch that crosses a page, because it needs a particular relation between `pc` and the offset, not just an opcode. The bench runs every one of the 256 offsets from program counters that sit near the end of a page, in mid-page, and at the top of the address space where the address wraps. This covers both backward and forward crossings, including the extreme offsets −128 and +127. The full opcode space is also swept under all four combinations of the page and taken inputs, so every undefined byte and every ignored input is checked.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

    localparam int CYC_BITS = 4;
    typedef logic [CYC_BITS-1:0] cyc_t;

    typedef enum logic [3:0] {
        MD_IMP  = 4'd0,
        MD_ACC  = 4'd1,
        MD_IMM  = 4'd2,
        MD_ZP   = 4'd3,
        MD_ZPX  = 4'd4,
        MD_ZPY  = 4'd5,
        MD_ABS  = 4'd6,
        MD_ABSX = 4'd7,
        MD_ABSY = 4'd8,
        MD_INDX = 4'd9,
        MD_INDY = 4'd10,
        MD_IND  = 4'd11,
        MD_REL  = 4'd12
    } amode_e;

    typedef enum logic [2:0] {
        IC_NONE   = 3'd0,
        IC_READ   = 3'd1,
        IC_WRITE  = 3'd2,
        IC_BRANCH = 3'd3,
        IC_OTHER  = 3'd4
    } iclass_e;

    typedef struct packed {
        logic    ok;
        amode_e  mode;
        iclass_e cls;
        cyc_t    ref_cyc;
    } dec_t;

    // Base cycle count from the family reference and the mode's adjustment
    function automatic cyc_t mode_adj(amode_e m, cyc_t r);
        case (m)
            MD_IMM:  return r - cyc_t'(2);
            MD_ZP:   return r - cyc_t'(1);
            MD_INDX: return r + cyc_t'(2);
            MD_INDY: return r + cyc_t'(1);
            MD_IND:  return r + cyc_t'(2);
            default: return r;
        endcase
    endfunction

    // Modes whose effective address is formed by adding an index to a 16-bit base
    function automatic logic page_mode(amode_e m);
        return (m == MD_ABSX) || (m == MD_ABSY) || (m == MD_INDY);
    endfunction

endpackage

// File: rtl/opdec_modemap.sv
module opdec_modemap
    import opdec_pkg::*;
(
    input  logic [7:0] op,
    output dec_t       dec
);
    logic [2:0] grp;
    logic [2:0] col;
    logic [1:0] lane;

    assign grp  = op[7:5];
    assign col  = op[4:2];
    assign lane = op[1:0];

    always_comb begin
        dec = '0;
        case (lane)
            2'b01: begin
                // accumulator family; store variant has no immediate form
                dec.ok      = !(grp == 3'b100 && col == 3'b010);
                dec.cls     = (grp == 3'b100) ? IC_WRITE : IC_READ;
                dec.ref_cyc = cyc_t'(4);
                case (col)
                    3'b000:  dec.mode = MD_INDX;
                    3'b001:  dec.mode = MD_ZP;
                    3'b010:  dec.mode = MD_IMM;
                    3'b011:  dec.mode = MD_ABS;
                    3'b100:  dec.mode = MD_INDY;
                    3'b101:  dec.mode = MD_ZPX;
                    3'b110:  dec.mode = MD_ABSY;
                    default: dec.mode = MD_ABSX;
                endcase
            end
            2'b10: begin
                if (col == 3'b010) begin
                    dec.ok      = 1'b1;
                    dec.cls     = IC_OTHER;
                    dec.ref_cyc = cyc_t'(2);
                    dec.mode    = grp[2] ? MD_IMP : MD_ACC;
                end else if (col == 3'b110) begin
                    dec.ok      = (grp == 3'b100) || (grp == 3'b101);
                    dec.cls     = IC_OTHER;
                    dec.ref_cyc = cyc_t'(2);
                    dec.mode    = MD_IMP;
                end else if (grp == 3'b100 || grp == 3'b101) begin
                    // index-register X store / load, Y indexing
                    dec.cls     = grp[0] ? IC_READ : IC_WRITE;
                    dec.ref_cyc = cyc_t'(4);
                    case (col)
                        3'b000:  begin dec.mode = MD_IMM;  dec.ok = grp[0]; end
                        3'b001:  begin dec.mode = MD_ZP;   dec.ok = 1'b1;   end
                        3'b011:  begin dec.mode = MD_ABS;  dec.ok = 1'b1;   end
                        3'b101:  begin dec.mode = MD_ZPY;  dec.ok = 1'b1;   end
                        3'b111:  begin dec.mode = MD_ABSY; dec.ok = grp[0]; end
                        default: dec.ok = 1'b0;
                    endcase
                end else begin
                    // read-modify-write on memory
                    dec.cls     = IC_WRITE;
                    dec.ref_cyc = cyc_t'(6);
                    case (col)
                        3'b001:  begin dec.mode = MD_ZP;   dec.ok = 1'b1; end
                        3'b011:  begin dec.mode = MD_ABS;  dec.ok = 1'b1; end
                        3'b101:  begin dec.mode = MD_ZPX;  dec.ok = 1'b1; end
                        3'b111:  begin dec.mode = MD_ABSX; dec.ok = 1'b1; end
                        default: dec.ok = 1'b0;
                    endcase
                end
            end
            2'b00: begin
                if (col == 3'b100) begin
                    dec.ok = 1'b1; dec.mode = MD_REL;
                    dec.cls = IC_BRANCH; dec.ref_cyc = cyc_t'(2);
                end else if (col == 3'b110) begin
                    dec.ok = 1'b1; dec.mode = MD_IMP;
                    dec.cls = IC_OTHER; dec.ref_cyc = cyc_t'(2);
                end else if (col == 3'b010) begin
                    // stack pushes 3, pulls 4, register steps 2
                    dec.ok = 1'b1; dec.mode = MD_IMP; dec.cls = IC_OTHER;
                    dec.ref_cyc = grp[2] ? cyc_t'(2) : (grp[0] ? cyc_t'(4) : cyc_t'(3));
                end else if (col == 3'b000) begin
                    case (grp)
                        3'b000: begin dec.ok = 1'b1; dec.mode = MD_IMP; dec.cls = IC_OTHER; dec.ref_cyc = cyc_t'(7); end
                        3'b001: begin dec.ok = 1'b1; dec.mode = MD_ABS; dec.cls = IC_OTHER; dec.ref_cyc = cyc_t'(6); end
                        3'b010,
                        3'b011: begin dec.ok = 1'b1; dec.mode = MD_IMP; dec.cls = IC_OTHER; dec.ref_cyc = cyc_t'(6); end
                        3'b100: dec.ok = 1'b0;
                        default: begin dec.ok = 1'b1; dec.mode = MD_IMM; dec.cls = IC_READ; dec.ref_cyc = cyc_t'(4); end
                    endcase
                end else begin
                    // operand forms: test, jump, Y store/load, compares
                    dec.cls = (grp == 3'b100) ? IC_WRITE :
                              ((grp == 3'b010 || grp == 3'b011) ? IC_OTHER : IC_READ);
                    dec.ref_cyc = (grp == 3'b010 || grp == 3'b011) ? cyc_t'(3) : cyc_t'(4);
                    case (col)
                        3'b001: begin
                            dec.mode = MD_ZP;
                            dec.ok   = (grp != 3'b000) && (grp != 3'b010) && (grp != 3'b011);
                        end
                        3'b011: begin
                            dec.mode = (grp == 3'b011) ? MD_IND : MD_ABS;
                            dec.ok   = (grp != 3'b000);
                        end
                        3'b101: begin
                            dec.mode = MD_ZPX;
                            dec.ok   = (grp == 3'b100) || (grp == 3'b101);
                        end
                        default: begin
                            dec.mode = MD_ABSX;
                            dec.ok   = (grp == 3'b101);
                        end
                    endcase
                end
            end
            default: dec.ok = 1'b0;
        endcase
        if (!dec.ok) dec = '0;
    end

endmodule

// File: rtl/opdec_reltarget.sv
module opdec_reltarget #(
    parameter int ADDR_W    = 16,
    parameter int OFF_W     = 8,
    parameter int PAGE_BITS = 8
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] target,
    output logic              far
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] nxt;
    logic [ADDR_W-1:0] ext;

    assign nxt    = pc + ADDR_W'(1);
    assign ext    = {{EXT_W{off[OFF_W-1]}}, off};
    assign target = nxt + ext;
    assign far    = target[ADDR_W-1:PAGE_BITS] != nxt[ADDR_W-1:PAGE_BITS];

endmodule

// File: rtl/opdec_cycles.sv
module opdec_cycles
    import opdec_pkg::*;
(
    input  dec_t dec,
    input  logic page_x,
    input  logic taken,
    input  logic far,
    output cyc_t base,
    output cyc_t total
);
    logic fixed_extra;

    assign fixed_extra = (dec.cls == IC_WRITE) && page_mode(dec.mode);
    assign base        = mode_adj(dec.mode, dec.ref_cyc) + cyc_t'(fixed_extra);

    always_comb begin
        case (dec.cls)
            IC_READ:   total = base + cyc_t'(page_mode(dec.mode) && page_x);
            IC_BRANCH: total = base + cyc_t'(taken) + cyc_t'(taken && far);
            default:   total = base;
        endcase
    end

endmodule

// File: rtl/opcode_cycle_decoder.sv
module opcode_cycle_decoder
    import opdec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 8,
    parameter int CYC_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        opcode,
    input  logic              page_x,
    input  logic              br_taken,
    input  logic [ADDR_W-1:0] pc,
    input  logic [OFF_W-1:0]  rel_off,
    output logic              valid_o,
    output logic [3:0]        mode_o,
    output logic [CYC_W-1:0]  base_cyc_o,
    output logic [CYC_W-1:0]  final_cyc_o,
    output logic [ADDR_W-1:0] target_o
);
    dec_t              dec;
    cyc_t              base_c;
    cyc_t              total_c;
    logic [ADDR_W-1:0] tgt_c;
    logic              far_c;

    opdec_modemap u_map (
        .op  (opcode),
        .dec (dec)
    );

    opdec_reltarget #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_rel (
        .pc     (pc),
        .off    (rel_off),
        .target (tgt_c),
        .far    (far_c)
    );

    opdec_cycles u_cyc (
        .dec    (dec),
        .page_x (page_x),
        .taken  (br_taken),
        .far    (far_c),
        .base   (base_c),
        .total  (total_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o     <= 1'b0;
            mode_o      <= 4'd0;
            base_cyc_o  <= '0;
            final_cyc_o <= '0;
            target_o    <= '0;
        end else begin
            valid_o     <= dec.ok;
            mode_o      <= dec.mode;
            base_cyc_o  <= CYC_W'(base_c);
            final_cyc_o <= CYC_W'(total_c);
            target_o    <= tgt_c;
        end
    end

    // Checks relating registered outputs to the sampled inputs
    logic [ADDR_W-1:0] chk_ext;
    assign chk_ext = {{(ADDR_W-OFF_W){rel_off[OFF_W-1]}}, rel_off};

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!valid_o && base_cyc_o == '0 && target_o == '0)); // R1
    AST_UNDEFINED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> (mode_o == 4'd0 && base_cyc_o == '0 && final_cyc_o == '0)); // R10
    AST_EXTRA_BOUND: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (final_cyc_o >= base_cyc_o && final_cyc_o <= base_cyc_o + CYC_W'(2))); // R8
    AST_SINGLE_EXTRA: assert property (@(posedge clk) disable iff (rst)
        (valid_o && mode_o != 4'd12) |-> (final_cyc_o <= base_cyc_o + CYC_W'(1))); // R6
    AST_UNTAKEN_TWO: assert property (@(posedge clk) disable iff (rst)
        (opcode[4:0] == 5'h10 && !br_taken) |=> (final_cyc_o == CYC_W'(2))); // R8
    AST_TARGET_SUM: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (target_o == $past(pc) + ADDR_W'(1) + $past(chk_ext))); // R9

endmodule

// File: tb/opcode_cycle_decoder_test.sv
module opcode_cycle_decoder_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  opcode = 8'h00;
    logic        page_x = 1'b0;
    logic        br_taken = 1'b0;
    logic [15:0] pc = 16'h0000;
    logic [7:0]  rel_off = 8'h00;
    logic        valid_o;
    logic [3:0]  mode_o;
    logic [3:0]  base_cyc_o;
    logic [3:0]  final_cyc_o;
    logic [15:0] target_o;

    opcode_cycle_decoder uut (
        .clk(clk), .rst(rst), .opcode(opcode), .page_x(page_x), .br_taken(br_taken),
        .pc(pc), .rel_off(rel_off), .valid_o(valid_o), .mode_o(mode_o),
        .base_cyc_o(base_cyc_o), .final_cyc_o(final_cyc_o), .target_o(target_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // expected tables: class 0 none, 1 read, 2 write, 3 branch, 4 other
    bit ev [256];
    int em [256];
    int eb [256];
    int ecl[256];

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s op=%02h pg=%0d tk=%0d pc=%04h off=%02h act=%0d exp=%0d",
                     req, what, opcode, page_x, br_taken, pc, rel_off, act, exp);
        end
    endtask

    function automatic int off_of(input int m, input int ab);
        case (m)
            1:  return -4;
            2:  return ((ab % 4) == 1) ? -4 : -12;
            3:  return -8;
            4, 5: return 8;
            7:  return 16;
            8:  return (ab == 'hAE) ? 16 : 12;
            9:  return -12;
            10: return 4;
            11: return 32;
            default: return 0;
        endcase
    endfunction

    function automatic int dlt(input int m);
        case (m)
            2: return -2;
            3: return -1;
            9, 11: return 2;
            10: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic bit idx_mode(input int m);
        return (m == 7) || (m == 8) || (m == 10);
    endfunction

    // R2 R3 R4 R5: one family placed by offsets from its absolute opcode
    task automatic fam(input int ab, input int rc, input int cl, input int mask);
        for (int m = 1; m <= 11; m++) begin
            if (mask[m]) begin
                int op;
                op = ab + off_of(m, ab);
                ev[op] = 1; em[op] = m;
                if (m == 1) begin eb[op] = 2; ecl[op] = 4; end
                else begin
                    eb[op] = rc + dlt(m) + ((cl == 2 && idx_mode(m)) ? 1 : 0);
                    ecl[op] = cl;
                end
            end
        end
    endtask

    task automatic imp(input int op, input int cyc);
        ev[op] = 1; em[op] = 0; eb[op] = cyc; ecl[op] = 4;
    endtask

    task automatic apply(input int op, input bit p, input bit t, input int a, input int o);
        @(negedge clk);
        opcode = 8'(op); page_x = p; br_taken = t; pc = 16'(a); rel_off = 8'(o);
        @(negedge clk);
    endtask

    localparam int B_ACC = 1 << 1, B_IMM = 1 << 2, B_ZP = 1 << 3, B_ZPX = 1 << 4, B_ZPY = 1 << 5;
    localparam int B_ABS = 1 << 6, B_ABX = 1 << 7, B_ABY = 1 << 8, B_INX = 1 << 9, B_INY = 1 << 10, B_IND = 1 << 11;

    initial begin
        int full;
        full = B_IMM | B_ZP | B_ZPX | B_ABS | B_ABX | B_ABY | B_INX | B_INY;
        for (int i = 0; i < 256; i++) begin ev[i] = 0; em[i] = 0; eb[i] = 0; ecl[i] = 0; end
        fam('h0D, 4, 1, full); fam('h2D, 4, 1, full); fam('h4D, 4, 1, full); fam('h6D, 4, 1, full);
        fam('hAD, 4, 1, full); fam('hCD, 4, 1, full); fam('hED, 4, 1, full);
        fam('h8D, 4, 2, full & ~B_IMM);
        fam('h0E, 6, 2, B_ACC | B_ZP | B_ZPX | B_ABS | B_ABX); fam('h2E, 6, 2, B_ACC | B_ZP | B_ZPX | B_ABS | B_ABX);
        fam('h4E, 6, 2, B_ACC | B_ZP | B_ZPX | B_ABS | B_ABX); fam('h6E, 6, 2, B_ACC | B_ZP | B_ZPX | B_ABS | B_ABX);
        fam('hCE, 6, 2, B_ZP | B_ZPX | B_ABS | B_ABX); fam('hEE, 6, 2, B_ZP | B_ZPX | B_ABS | B_ABX);
        fam('hAE, 4, 1, B_IMM | B_ZP | B_ZPY | B_ABS | B_ABY);
        fam('h8E, 4, 2, B_ZP | B_ZPY | B_ABS);
        fam('hAC, 4, 1, B_IMM | B_ZP | B_ZPX | B_ABS | B_ABX);
        fam('h8C, 4, 2, B_ZP | B_ZPX | B_ABS);
        fam('hCC, 4, 1, B_IMM | B_ZP | B_ABS); fam('hEC, 4, 1, B_IMM | B_ZP | B_ABS);
        fam('h2C, 4, 1, B_ZP | B_ABS);
        fam('h4C, 3, 4, B_ABS | B_IND);
        fam('h20, 6, 4, B_ABS);
        // R7 implied opcodes
        imp('h18, 2); imp('h38, 2); imp('h58, 2); imp('h78, 2); imp('h98, 2); imp('hB8, 2);
        imp('hD8, 2); imp('hF8, 2); imp('h88, 2); imp('hA8, 2); imp('hC8, 2); imp('hE8, 2);
        imp('h8A, 2); imp('h9A, 2); imp('hAA, 2); imp('hBA, 2); imp('hCA, 2); imp('hEA, 2);
        imp('h08, 3); imp('h48, 3); imp('h28, 4); imp('h68, 4); imp('h40, 6); imp('h60, 6); imp('h00, 7);
        // R8 branches
        for (int k = 0; k < 8; k++) begin
            ev[k*32+16] = 1; em[k*32+16] = 12; eb[k*32+16] = 2; ecl[k*32+16] = 3;
        end

        // R1: reset holds outputs clear even with a defined opcode present
        rst = 1'b1; opcode = 8'h6D; pc = 16'h1234; rel_off = 8'h05;
        repeat (3) @(negedge clk);
        chk("R1", "valid", int'(valid_o), 0);
        chk("R1", "base", int'(base_cyc_o), 0);
        chk("R1", "final", int'(final_cyc_o), 0);
        chk("R1", "target", int'(target_o), 0);
        rst = 1'b0;
        @(negedge clk);
        // R1: one edge after release the sampled opcode shows up
        chk("R1", "valid after release", int'(valid_o), 1);
        chk("R1", "base after release", int'(base_cyc_o), 4);

        // R2..R8, R10: sweep every opcode under every page/taken pair, same-page branch
        for (int op = 0; op < 256; op++) begin
            for (int pt = 0; pt < 4; pt++) begin
                bit p, t;
                int fin;
                p = pt[0]; t = pt[1];
                apply(op, p, t, 'h1234, 0);
                fin = eb[op];
                if (ecl[op] == 1 && idx_mode(em[op]) && p) fin = fin + 1;   // R6
                if (ecl[op] == 3 && t) fin = fin + 1;                         // R8 near
                chk(ev[op] ? "R2" : "R10", "valid", int'(valid_o), int'(ev[op]));
                chk("R2", "mode", int'(mode_o), em[op]);
                chk(ev[op] ? "R4" : "R10", "base", int'(base_cyc_o), eb[op]);
                chk(ecl[op] == 1 ? "R6" : (ecl[op] == 3 ? "R8" : "R10"), "final", int'(final_cyc_o), fin);
            end
        end

        // R8 R9: branch target and far-page cycle over all offsets and edge pcs
        for (int q = 0; q < 5; q++) begin
            int a;
            case (q)
                0: a = 'h10F0;
                1: a = 'h10FE;
                2: a = 'h1080;
                3: a = 'hFFFF;
                default: a = 'h0000;
            endcase
            for (int o = 0; o < 256; o++) begin
                int so, nx, tg, fr;
                so = (o >= 128) ? o - 256 : o;
                nx = (a + 1) & 'hFFFF;
                tg = (nx + so) & 'hFFFF;
                fr = ((tg >> 8) != (nx >> 8)) ? 1 : 0;
                apply('hD0, (o % 2) == 1, 1'b1, a, o);
                chk("R9", "target", int'(target_o), tg);
                chk("R8", "taken final", int'(final_cyc_o), 3 + fr);
            end
        end
        // R8: untaken branch stays at 2 even toward another page with page_x set
        apply('h30, 1'b1, 1'b0, 'h10FE, 'h40);
        chk("R8", "untaken far", int'(final_cyc_o), 2);
        chk("R9", "untaken target", int'(target_o), 'h113F);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule